// File: doc/BRIEF.md
# Push Buffer Command Stream Decoder

This block sits at the front of a graphics command processor. It accepts a stream of 32-bit words from a command list on a valid/ready input, splits it into header words and the argument words that follow each header, and turns the result into individual register writes for downstream engines. Each write carries a subchannel, a method index, a 32-bit data value and the engine ID that is currently bound to that subchannel.

Each header picks one of several addressing schemes. Arguments can go to consecutive methods, all to one method, or the first to the header's method and the rest to the next one. A header can also carry one 13-bit value of its own, with no argument words after it. Methods in the low window are executed inside the block. Method 0 binds an engine ID to a subchannel in an eight-entry table. All other methods are forwarded on a registered valid/ready output. Two sticky flags report headers with a reserved mode and writes that target a subchannel with no engine bound.

Top module: `pbuf_decoder`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, both error flags are 0, no subchannel is bound, and the first accepted word is parsed as a header.
- R2: A header has this layout: method index in bits 12:0, subchannel in bits 15:13, count or inline value in bits 28:16, mode in bits 31:29. In mode 1 (and its alias, mode 0) the next `count` words are arguments. Argument k is written to method+k, and the method index wraps modulo 8192.
- R3: In mode 3 (and its alias, mode 2) the next `count` words are all written to the header's method.
- R4: In mode 4, no argument words follow. The header produces exactly one write whose data is bits 28:16 of the header, zero-extended to 32 bits.
- R5: In mode 5, the first argument goes to the header's method and every later argument goes to method+1.
- R6: A header with count 0 in mode 0, 1, 2, 3 or 5 produces no write, and the next word is parsed as a header.
- R7: Writes to a method index below 0x40 (byte address below 0x100) never appear on the output. A write to method 0 binds bits 15:0 of its data as the engine ID of the write's subchannel, and later forwarded writes on that subchannel carry the new ID.
- R8: Every forwarded write carries the engine ID bound to its subchannel. A write at or above method 0x40 to an unbound subchannel is dropped and sets `err_unbound`, which stays set until reset.
- R9: A header in mode 6 or 7 sets the sticky `err_mode` flag, consumes only its own word and produces no write. The following word is parsed as a header.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output fields hold stable and `in_ready` is 0. Writes leave in the order the words arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word is offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Block takes the word this cycle |
| out_valid | output | 1 | A method write is presented |
| out_ready | input | 1 | Downstream takes the write |
| out_subch | output | 3 | Subchannel of the write |
| out_method | output | 13 | Method index (byte address / 4) |
| out_data | output | 32 | Write data |
| out_engine | output | 16 | Engine ID bound to the subchannel |
| err_mode | output | 1 | Sticky: a reserved mode was seen |
| err_unbound | output | 1 | Sticky: a write to an unbound subchannel was dropped |

## Verification
A wrong argument counter or parse state shows at the ports within one word. A header is then taken as data, or data as a header, which yields a write with a nonsense method or subchannel, or a missing write, on the next handshake. A wrong method step shows on the second argument of a burst, and a stale binding table shows on the first forwarded write after a rebind. The bench runs a behavioural model of the stream alongside the design under random output back-pressure. It compares each write when it leaves, so a divergence is flagged on the cycle of the first wrong write.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam int WORD_W  = 32;
  localparam int METH_W  = 13;
  localparam int SUBCH_W = 3;
  localparam int CNT_W   = 13;
  localparam int ENG_W   = 16;

  // Addressing scheme applied to the argument words of a header
  typedef enum logic [1:0] {
    SEQ_INCR = 2'd0,
    SEQ_SAME = 2'd1,
    SEQ_ONCE = 2'd2
  } seq_e;

  typedef struct packed {
    logic [METH_W-1:0]  method;
    logic [SUBCH_W-1:0] subch;
    logic [CNT_W-1:0]   cnt;
    seq_e               seq;
    logic               imm;
    logic               bad;
  } hdr_t;
endpackage

// File: rtl/pbuf_hdr_decode.sv
module pbuf_hdr_decode
  import pbuf_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_t              hdr
);
  logic [2:0] mode;

  always_comb begin
    mode       = word[31:29];
    hdr.method = word[METH_W-1:0];
    hdr.subch  = word[15:13];
    hdr.cnt    = word[28:16];
    hdr.seq    = SEQ_INCR;
    hdr.imm    = 1'b0;
    hdr.bad    = 1'b0;
    case (mode)
      3'd0, 3'd1: hdr.seq = SEQ_INCR;
      3'd2, 3'd3: hdr.seq = SEQ_SAME;
      3'd4:       hdr.imm = 1'b1;
      3'd5:       hdr.seq = SEQ_ONCE;
      default:    hdr.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/pbuf_bind_table.sv
module pbuf_bind_table #(
  parameter int N_SUB = 8,
  parameter int ENG_W = 16,
  localparam int IDX_W = $clog2(N_SUB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENG_W-1:0] wr_eng,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bound,
  output logic [ENG_W-1:0] rd_eng
);
  logic [N_SUB-1:0]             bound_q;
  logic [N_SUB-1:0][ENG_W-1:0]  eng_q;

  for (genvar g = 0; g < N_SUB; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bound_q[g] <= 1'b0;
        eng_q[g]   <= '0;
      end else if (hit) begin
        bound_q[g] <= 1'b1;
        eng_q[g]   <= wr_eng;
      end
    end
  end

  assign rd_bound = bound_q[rd_idx];
  assign rd_eng   = eng_q[rd_idx];

  // A bound entry never becomes unbound before reset
  AST_BIND_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    bound_q[rd_idx] |=> bound_q[$past(rd_idx)]) else $error("bind lost"); // R7
endmodule

// File: rtl/pbuf_out_stage.sv
module pbuf_out_stage
  import pbuf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SUBCH_W-1:0] ld_subch,
  input  logic [METH_W-1:0]  ld_method,
  input  logic [WORD_W-1:0]  ld_data,
  input  logic [ENG_W-1:0]   ld_engine,
  input  logic               out_ready,
  output logic               can_take,
  output logic               out_valid,
  output logic [SUBCH_W-1:0] out_subch,
  output logic [METH_W-1:0]  out_method,
  output logic [WORD_W-1:0]  out_data,
  output logic [ENG_W-1:0]   out_engine
);
  logic valid_d;

  assign can_take = !out_valid || out_ready;

  always_comb begin
    valid_d = out_valid;
    if (load)            valid_d = 1'b1;
    else if (out_ready)  valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_subch  <= '0;
      out_method <= '0;
      out_data   <= '0;
      out_engine <= '0;
    end else if (load) begin
      out_subch  <= ld_subch;
      out_method <= ld_method;
      out_data   <= ld_data;
      out_engine <= ld_engine;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_method) && $stable(out_subch) && $stable(out_engine)))
    else $error("output changed under stall"); // R10
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !load) else $error("load while full"); // R10
endmodule

// File: rtl/pbuf_decoder.sv
module pbuf_decoder
  import pbuf_pkg::*;
#(
  parameter int INT_BYTE_LIMIT = 'h100,
  parameter int N_SUB          = 8,
  localparam int INT_LIMIT     = INT_BYTE_LIMIT / 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   in_data,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_subch,
  output logic [12:0]   out_method,
  output logic [31:0]   out_data,
  output logic [15:0]   out_engine,
  output logic          err_mode,
  output logic          err_unbound
);
  hdr_t               hdr;
  logic               accept;
  logic               can_take;

  // Parse state: remaining argument words and the running target
  logic [CNT_W-1:0]   rem_q,  rem_d;
  logic [METH_W-1:0]  meth_q, meth_d;
  logic [SUBCH_W-1:0] sub_q,  sub_d;
  seq_e               seq_q,  seq_d;
  logic               st_en;

  // Write issued by the current word
  logic               iss_en;
  logic [METH_W-1:0]  iss_meth;
  logic [SUBCH_W-1:0] iss_sub;
  logic [WORD_W-1:0]  iss_data;
  logic               iss_internal;
  logic               bind_wr;
  logic               fwd;
  logic               rd_bound;
  logic [ENG_W-1:0]   rd_eng;
  logic               load;
  logic               set_unb, set_mode;
  logic               err_mode_d, err_unb_d;

  pbuf_hdr_decode u_hdr (.word(in_data), .hdr(hdr));

  assign in_ready = can_take;
  assign accept   = in_valid && in_ready;

  always_comb begin
    rem_d    = rem_q;
    meth_d   = meth_q;
    sub_d    = sub_q;
    seq_d    = seq_q;
    iss_en   = 1'b0;
    iss_meth = meth_q;
    iss_sub  = sub_q;
    iss_data = in_data;
    set_mode = 1'b0;
    if (accept) begin
      if (rem_q == '0) begin
        if (hdr.bad) begin
          set_mode = 1'b1;
        end else if (hdr.imm) begin
          iss_en   = 1'b1;
          iss_meth = hdr.method;
          iss_sub  = hdr.subch;
          iss_data = WORD_W'(hdr.cnt);
        end else begin
          rem_d  = hdr.cnt;
          meth_d = hdr.method;
          sub_d  = hdr.subch;
          seq_d  = hdr.seq;
        end
      end else begin
        iss_en = 1'b1;
        rem_d  = rem_q - 1'b1;
        case (seq_q)
          SEQ_INCR: meth_d = meth_q + 1'b1;
          SEQ_ONCE: begin
            meth_d = meth_q + 1'b1;
            seq_d  = SEQ_SAME;
          end
          default:  meth_d = meth_q;
        endcase
      end
    end
  end

  assign st_en = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      meth_q <= '0;
      sub_q  <= '0;
      seq_q  <= SEQ_INCR;
    end else if (st_en) begin
      rem_q  <= rem_d;
      meth_q <= meth_d;
      sub_q  <= sub_d;
      seq_q  <= seq_d;
    end
  end

  // Routing: low window internal, the rest forwarded if bound
  always_comb begin
    iss_internal = (32'(iss_meth) < INT_LIMIT);
    bind_wr      = iss_en && (iss_meth == '0);
    fwd          = iss_en && !iss_internal;
    load         = fwd && rd_bound;
    set_unb      = fwd && !rd_bound;
    err_mode_d   = err_mode || set_mode;
    err_unb_d    = err_unbound || set_unb;
  end

  pbuf_bind_table #(.N_SUB(N_SUB), .ENG_W(ENG_W)) u_bind (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bind_wr),
    .wr_idx   (iss_sub),
    .wr_eng   (iss_data[ENG_W-1:0]),
    .rd_idx   (iss_sub),
    .rd_bound (rd_bound),
    .rd_eng   (rd_eng)
  );

  pbuf_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .ld_subch   (iss_sub),
    .ld_method  (iss_meth),
    .ld_data    (iss_data),
    .ld_engine  (rd_eng),
    .out_ready  (out_ready),
    .can_take   (can_take),
    .out_valid  (out_valid),
    .out_subch  (out_subch),
    .out_method (out_method),
    .out_data   (out_data),
    .out_engine (out_engine)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_mode    <= 1'b0;
      err_unbound <= 1'b0;
    end else begin
      err_mode    <= err_mode_d;
      err_unbound <= err_unb_d;
    end
  end

  AST_FWD_ABOVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_method) >= INT_LIMIT)) else $error("internal forwarded"); // R7
  AST_IMM_NO_ARGS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rem_q == '0 && hdr.imm) |=> (rem_q == '0)) else $error("imm took args"); // R4
  AST_BAD_NO_ARGS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rem_q == '0 && hdr.bad) |=> (rem_q == '0 && err_mode)) else $error("bad mode"); // R9
  AST_UNB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_unbound |=> err_unbound) else $error("unbound flag cleared"); // R8
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |=> err_mode) else $error("mode flag cleared"); // R9
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready) else $error("input taken under stall"); // R10
  AST_ARG_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rem_q != '0) |=> (rem_q == $past(rem_q) - 1'b1)) else $error("count"); // R2
endmodule

// File: tb/pbuf_decoder_bench.sv
`timescale 1ns/1ps
module pbuf_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_subch;
  logic [12:0] out_method;
  logic [31:0] out_data;
  logic [15:0] out_engine;
  logic        err_mode, err_unbound;

  always #4 clk = ~clk;

  pbuf_decoder u_pbuf_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_subch(out_subch), .out_method(out_method), .out_data(out_data),
    .out_engine(out_engine), .err_mode(err_mode), .err_unbound(err_unbound)
  );

  int errors = 0;
  int checks = 0;
  bit stall_on = 1'b0;
  bit done = 1'b0;

  // Behavioural model state
  logic [63:0] exp_q[$];
  string       tag_q[$];
  string       cur_tag = "R2";
  int          m_rem = 0, m_meth = 0, m_sub = 0, m_kind = 0;
  bit          m_bound[8];
  int          m_eng[8];
  bit          exp_err_mode = 0, exp_err_unb = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input int meth, input int sub, input logic [31:0] d);
    if (meth < 'h40) begin
      if (meth == 0) begin
        m_bound[sub] = 1;
        m_eng[sub] = int'(d[15:0]);
      end
    end else if (!m_bound[sub]) begin
      exp_err_unb = 1;
    end else begin
      exp_q.push_back({16'(m_eng[sub]), 3'(sub), 13'(meth), d});
      tag_q.push_back(cur_tag);
    end
  endtask

  task automatic model_word(input logic [31:0] w);
    int mode;
    if (m_rem == 0) begin
      mode = int'(w[31:29]);
      if (mode >= 6) exp_err_mode = 1;
      else if (mode == 4) issue(int'(w[12:0]), int'(w[15:13]), 32'(w[28:16]));
      else begin
        m_rem  = int'(w[28:16]);
        m_meth = int'(w[12:0]);
        m_sub  = int'(w[15:13]);
        m_kind = (mode <= 1) ? 0 : (mode <= 3) ? 1 : 2;
      end
    end else begin
      issue(m_meth, m_sub, w);
      m_rem--;
      if (m_kind == 0) m_meth = (m_meth + 1) % 8192;
      else if (m_kind == 2) begin
        m_meth = (m_meth + 1) % 8192;
        m_kind = 1;
      end
    end
  endtask

  function automatic logic [31:0] hdr(input int mode, input int cnt,
                                      input int sub, input int meth);
    return {3'(mode), 13'(cnt), 3'(sub), 13'(meth)};
  endfunction

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    model_word(w);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !out_valid) break;
    end
    check(exp_q.size() == 0, cur_tag, "writes missing", exp_q.size(), 0);
  endtask

  // Output back-pressure, changed well after the edge
  always @(posedge clk) begin
    #2;
    out_ready = stall_on ? (($urandom % 3) != 0) : 1'b1;
  end

  // Per-cycle comparison against the model
  logic [63:0] held;
  bit          was_stalled = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stalled)
        check({out_engine, out_subch, out_method, out_data} == held && out_valid,
              "R10", "stalled output changed",
              {out_engine, out_subch, out_method, out_data}, held);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          check(0, cur_tag, "unexpected write", {out_engine, out_subch, out_method, out_data}, 0);
        else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_engine, out_subch, out_method, out_data} == e, t, "write",
                {out_engine, out_subch, out_method, out_data}, e);
        end
      end
      if (out_valid && !out_ready)
        check(!in_ready, "R10", "in_ready under stall", in_ready, 0);
      was_stalled = out_valid && !out_ready;
      held = {out_engine, out_subch, out_method, out_data};
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_bound[i] = 0; m_eng[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready, "R1", "in_ready after reset", in_ready, 1);
    check(!err_mode && !err_unbound, "R1", "flags after reset", {err_mode, err_unbound}, 0);

    // R8 unbound subchannel: dropped, sticky flag
    cur_tag = "R8";
    send(hdr(4, 'h55, 5, 'h100));
    drain();
    @(negedge clk);
    check(err_unbound == 1'b1, "R8", "err_unbound", err_unbound, 1);

    // R7 binds through method 0
    cur_tag = "R7";
    send(hdr(1, 1, 0, 0)); send(32'h0000_B197);
    send(hdr(1, 1, 2, 0)); send(32'hFFFF_902D);
    send(hdr(4, 'h1ABC, 2, 'h200));
    drain();

    // R2 incrementing, modes 1 and 0, with back-pressure
    stall_on = 1;
    cur_tag = "R2";
    send(hdr(1, 4, 0, 'h400));
    for (int i = 0; i < 4; i++) send(32'hA000_0000 + i);
    send(hdr(0, 3, 2, 'h1FFE));
    for (int i = 0; i < 3; i++) send(32'h1234_0000 + i);
    drain();

    // R3 non-incrementing, modes 3 and 2
    cur_tag = "R3";
    send(hdr(3, 3, 0, 'h321));
    for (int i = 0; i < 3; i++) send(32'hB000_0000 + i);
    send(hdr(2, 2, 2, 'h77));
    for (int i = 0; i < 2; i++) send(32'hC000_0000 + i);
    drain();

    // R4 immediate
    cur_tag = "R4";
    send(hdr(4, 'h1FFF, 0, 'h500));
    send(hdr(4, 0, 2, 'h40));
    drain();

    // R5 increment-once
    cur_tag = "R5";
    send(hdr(5, 4, 0, 'h600));
    for (int i = 0; i < 4; i++) send(32'hD000_0000 + i);
    drain();

    // R6 zero count: next word is a header
    cur_tag = "R6";
    send(hdr(1, 0, 0, 'h700));
    send(hdr(4, 'h11, 0, 'h701));
    send(hdr(5, 0, 2, 'h702));
    send(hdr(3, 1, 2, 'h703)); send(32'h0BAD_F00D);
    drain();

    // R7 internal methods never forwarded
    cur_tag = "R7";
    send(hdr(1, 2, 0, 'h10)); send(32'h1); send(32'h2);
    send(hdr(4, 5, 0, 'h3F));
    send(hdr(4, 6, 0, 'h40));
    drain();

    // R9 reserved modes
    cur_tag = "R9";
    check(err_mode == 1'b0, "R9", "err_mode before", err_mode, 0);
    send(hdr(6, 3, 0, 'h800));
    send(hdr(4, 'h22, 0, 'h801));
    send(hdr(7, 1, 0, 'h802));
    send(hdr(4, 'h23, 0, 'h803));
    drain();
    @(negedge clk);
    check(err_mode == 1'b1, "R9", "err_mode after", err_mode, 1);

    // R7 rebind changes the engine carried by later writes
    cur_tag = "R7";
    send(hdr(1, 1, 0, 0)); send(32'h0000_B1C0);
    send(hdr(4, 9, 0, 'h900));
    drain();

    // R8 random stream over bound and unbound subchannels
    cur_tag = "R8";
    for (int n = 0; n < 300; n++) begin
      int mode, cnt, sub, meth;
      mode = $urandom % 6;
      cnt  = $urandom % 4;
      sub  = $urandom % 4;
      meth = ($urandom % 10 == 0) ? 0 : 'h40 + ($urandom % 'h100);
      send(hdr(mode, cnt, sub, meth));
      if (mode != 4) for (int k = 0; k < cnt; k++) send($urandom);
    end
    drain();
    @(negedge clk);
    check(err_unbound == exp_err_unb, "R8", "err_unbound final", err_unbound, exp_err_unb);
    check(err_mode == exp_err_mode, "R9", "err_mode final", err_mode, exp_err_mode);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule